// File: doc/BRIEF.md
# SDRAM Open-Page Read Sequencer

This block turns single-word read requests into SDRAM command sequences for an external memory port. A request carries a row, a column, a byte-enable pattern and a tag. The sequencer keeps one page open and remembers its row. A request to that row is served with a column read alone. A request to any other row first closes every bank, then opens the new row, and only then reads.

Reads use burst length one and CAS latency three. The sequencer registers the data word three cycles after the column command and returns it with a valid strobe and the request's tag, in request order. After the last read of a run, one idle cycle separates it from the next command. The close-all command is held back until a request to a different page is present, so the page stays open through quiet periods. The bank-select bits at the top of the address bus keep the values they had at activation during column reads and during close-all.

Top module: `sdram_page_rd_seq`

## Requirements
- R1: While reset is asserted and after it is released, the command pins show no-operation ({ras_n,cas_n,we_n}=111), rd_valid is 0 and no page is open, so the first request always begins with an activate.
- R2: Activate drives {ras_n,cas_n,we_n}=011, places req_row[ADDR_W-1:0] on sd_addr and req_row[ADDR_W] on sd_a10, and is issued when a request is pending and no page is open.
- R3: A request whose row equals the open row issues a read ({ras_n,cas_n,we_n}=101) with sd_a10=0, req_col on sd_addr[COL_W-1:0] and zeros between the column and the held bits. Hits on consecutive cycles issue one read per cycle.
- R4: rd_valid pulses for one cycle at the CAS_LAT-th rising edge after the edge that launched the read, with rd_data holding sd_dq_in as sampled at that edge and rd_tag holding the request's tag, in request order.
- R5: The cycle after the last read of a run is a no-operation, whatever request is pending.
- R6: A pending request to a different row, with a page open and no read in the previous cycle, issues close-all ({ras_n,cas_n,we_n}=010, sd_a10=1, sd_addr bits below the held bits zero). It closes the page, so the next command for that request is an activate.
- R7: With no request pending, or with a request to the open row, no close-all is issued and the page stays open; a later hit reads without a new activate.
- R8: During reads and close-all, sd_addr[ADDR_W-1:ADDR_W-HOLD_W] equals the value those bits had at the most recent activate.
- R9: sd_be_n is the inverse of req_be on each read command, so each read carries its own pattern. On every other command it is all ones.
- R10: req_ready is high exactly in a cycle where a read is issued for the presented request; the request is consumed at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A read request is presented |
| req_row | input | ADDR_W+1 | Row of the request; top bit travels on sd_a10 at activate |
| req_col | input | COL_W | Column of the request |
| req_be | input | BE_W | Byte enables of the request, active high |
| req_tag | input | TAG_W | Tag returned with the data |
| req_ready | output | 1 | Request consumed this cycle |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_a10 | output | 1 | Address line 10 function: row bit, auto-precharge off, close-all select |
| sd_addr | output | ADDR_W | SDRAM address bus; top HOLD_W bits select bank/row |
| sd_be_n | output | BE_W | Byte masks, active low |
| sd_dq_in | input | DATA_W | Data bus from the SDRAM |
| rd_valid | output | 1 | Returned data is valid |
| rd_data | output | DATA_W | Returned data word |
| rd_tag | output | TAG_W | Tag of the returned word |

## Verification
The bench builds the block with its defaults: a 14-bit address with three held bits, an 8-bit column, CAS latency three and a 4-bit tag. Rows are chosen so they differ only in the held bits, only in the bit that travels on sd_a10, or only in the lowest row bit. That tests the page comparison over the full row and shows whether the held bits are driven from the activate-time value. The 4-bit tag wraps during a long hit run, so in-order return is checked across tag reuse. Data on sd_dq_in changes every cycle, so a capture one cycle early or late returns a different word.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_RD   = 2'd2,
    CMD_DCAB = 2'd3
  } sdr_cmd_e;

  // {ras_n, cas_n, we_n}
  function automatic logic [2:0] cmd_strobes(sdr_cmd_e c);
    case (c)
      CMD_ACT:  return 3'b011;
      CMD_RD:   return 3'b101;
      CMD_DCAB: return 3'b010;
      default:  return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/sdr_rst_sync.sv
module sdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sdr_page_track.sv
module sdr_page_track #(
  parameter int ADDR_W = 14,
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_en,
  input  logic              close_en,
  input  logic [ADDR_W:0]   req_row,
  output logic              page_vld,
  output logic              page_hit,
  output logic [HOLD_W-1:0] held_hi
);
  localparam int ROW_W = ADDR_W + 1;

  logic             vld_q, vld_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             row_en;

  always_comb begin
    vld_d  = vld_q;
    row_d  = row_q;
    row_en = 1'b0;
    if (open_en) begin
      vld_d  = 1'b1;
      row_d  = req_row;
      row_en = 1'b1;
    end else if (close_en) begin
      vld_d  = 1'b0;
      row_d  = '0;
      row_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      row_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (row_en) row_q <= row_d;
    end
  end

  assign page_vld = vld_q;
  assign page_hit = vld_q && (row_q == req_row);
  assign held_hi  = row_q[ADDR_W-1 -: HOLD_W];
endmodule

// File: rtl/sdr_cmd_ctl.sv
module sdr_cmd_ctl
  import sdr_rd_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int HOLD_W = 3,
  parameter int COL_W  = 8,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W:0]   req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [BE_W-1:0]   req_be,
  input  logic              page_vld,
  input  logic              page_hit,
  input  logic [HOLD_W-1:0] held_hi,
  output sdr_cmd_e          cmd_d,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_a10,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BE_W-1:0]   sd_be_n
);
  logic              last_rd_q;
  logic [2:0]        strb_d, strb_q;
  logic              a10_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BE_W-1:0]   be_n_d;

  // command choice: hit wins, then the post-read gap, then open, then close
  always_comb begin
    cmd_d = CMD_NOP;
    if (req_valid && page_vld && page_hit) cmd_d = CMD_RD;
    else if (last_rd_q)                    cmd_d = CMD_NOP;
    else if (req_valid && !page_vld)       cmd_d = CMD_ACT;
    else if (req_valid)                    cmd_d = CMD_DCAB;
  end

  always_comb begin
    strb_d = cmd_strobes(cmd_d);
    a10_d  = 1'b0;
    addr_d = '0;
    be_n_d = '1;
    case (cmd_d)
      CMD_ACT: begin
        addr_d = req_row[ADDR_W-1:0];
        a10_d  = req_row[ADDR_W];
      end
      CMD_RD: begin
        addr_d[COL_W-1:0]         = req_col;
        addr_d[ADDR_W-1 -: HOLD_W] = held_hi;
        be_n_d                    = ~req_be;
      end
      CMD_DCAB: begin
        addr_d[ADDR_W-1 -: HOLD_W] = held_hi;
        a10_d                     = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rd_q <= 1'b0;
      strb_q    <= 3'b111;
      sd_a10    <= 1'b0;
      sd_addr   <= '0;
      sd_be_n   <= '1;
    end else begin
      last_rd_q <= (cmd_d == CMD_RD);
      strb_q    <= strb_d;
      sd_a10    <= a10_d;
      sd_addr   <= addr_d;
      sd_be_n   <= be_n_d;
    end
  end

  assign {sd_ras_n, sd_cas_n, sd_we_n} = strb_q;
endmodule

// File: rtl/sdr_rd_return.sv
module sdr_rd_return #(
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4,
  parameter int CAS_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [TAG_W-1:0]  launch_tag,
  input  logic [DATA_W-1:0] sd_dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag
);
  localparam int LAST = CAS_LAT - 1;

  logic [CAS_LAT-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [CAS_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q[0] <= 1'b0;
      tag_q[0] <= '0;
    end else begin
      vld_q[0] <= launch;
      if (launch) tag_q[0] <= launch_tag;
    end
  end

  for (genvar s = 1; s < CAS_LAT; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
        tag_q[s] <= '0;
      end else begin
        vld_q[s] <= vld_q[s-1];
        if (vld_q[s-1]) tag_q[s] <= tag_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_tag   <= '0;
    end else begin
      rd_valid <= vld_q[LAST];
      if (vld_q[LAST]) begin
        rd_data <= sd_dq_in;
        rd_tag  <= tag_q[LAST];
      end
    end
  end
endmodule

// File: rtl/sdram_page_rd_seq.sv
module sdram_page_rd_seq
  import sdr_rd_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int HOLD_W  = 3,
  parameter int COL_W   = 8,
  parameter int BE_W    = 4,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4,
  parameter int CAS_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W:0]   req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [BE_W-1:0]   req_be,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              req_ready,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_a10,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BE_W-1:0]   sd_be_n,
  input  logic [DATA_W-1:0] sd_dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag
);
  logic              rst_i_n;
  logic              page_vld, page_hit;
  logic [HOLD_W-1:0] held_hi;
  sdr_cmd_e          cmd_d;

  sdr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  sdr_page_track #(.ADDR_W(ADDR_W), .HOLD_W(HOLD_W)) u_page (
    .clk(clk), .rst_n(rst_i_n),
    .open_en(cmd_d == CMD_ACT), .close_en(cmd_d == CMD_DCAB),
    .req_row(req_row), .page_vld(page_vld), .page_hit(page_hit),
    .held_hi(held_hi)
  );

  sdr_cmd_ctl #(.ADDR_W(ADDR_W), .HOLD_W(HOLD_W), .COL_W(COL_W), .BE_W(BE_W)) u_cmd (
    .clk(clk), .rst_n(rst_i_n),
    .req_valid(req_valid), .req_row(req_row), .req_col(req_col), .req_be(req_be),
    .page_vld(page_vld), .page_hit(page_hit), .held_hi(held_hi),
    .cmd_d(cmd_d),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_a10(sd_a10), .sd_addr(sd_addr), .sd_be_n(sd_be_n)
  );

  sdr_rd_return #(.DATA_W(DATA_W), .TAG_W(TAG_W), .CAS_LAT(CAS_LAT)) u_ret (
    .clk(clk), .rst_n(rst_i_n),
    .launch(cmd_d == CMD_RD), .launch_tag(req_tag), .sd_dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag)
  );

  assign req_ready = (cmd_d == CMD_RD);
endmodule

// File: rtl/sdr_rd_seq_chk.sv
module sdr_rd_seq_chk #(
  parameter int ADDR_W  = 14,
  parameter int HOLD_W  = 3,
  parameter int BE_W    = 4,
  parameter int CAS_LAT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic              sd_a10,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BE_W-1:0]   sd_be_n,
  input logic              rd_valid
);
  logic is_act, is_rd, is_dcab, is_nop;
  assign is_act  = !sd_ras_n &&  sd_cas_n &&  sd_we_n;
  assign is_rd   =  sd_ras_n && !sd_cas_n &&  sd_we_n;
  assign is_dcab = !sd_ras_n &&  sd_cas_n && !sd_we_n;
  assign is_nop  =  sd_ras_n &&  sd_cas_n &&  sd_we_n;

  logic              seen_act_q;
  logic [HOLD_W-1:0] held_q;
  logic [CAS_LAT-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_act_q <= 1'b0;
      held_q     <= '0;
      hist_q     <= '0;
    end else begin
      if (is_act) begin
        seen_act_q <= 1'b1;
        held_q     <= sd_addr[ADDR_W-1 -: HOLD_W];
      end
      hist_q <= {hist_q[CAS_LAT-2:0], is_rd};
    end
  end

  p_legal_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_act || is_rd || is_dcab || is_nop);
  p_read_no_ap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> !sd_a10);
  p_data_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == hist_q[CAS_LAT-1]);
  p_gap_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> (is_rd || is_nop));
  p_dcab_a10_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_dcab |-> sd_a10);
  p_reopen_after_dcab_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_dcab |=> !is_rd);
  p_held_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_act_q && (is_rd || is_dcab)) |-> (sd_addr[ADDR_W-1 -: HOLD_W] == held_q));
  p_mask_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |-> (&sd_be_n));
  p_ready_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
endmodule

bind sdram_page_rd_seq sdr_rd_seq_chk #(
  .ADDR_W(ADDR_W), .HOLD_W(HOLD_W), .BE_W(BE_W), .CAS_LAT(CAS_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_a10(sd_a10), .sd_addr(sd_addr), .sd_be_n(sd_be_n), .rd_valid(rd_valid)
);

// File: tb/tb_sdram_page_rd_seq.sv
module tb_sdram_page_rd_seq;
  localparam int ADDR_W = 14, HOLD_W = 3, COL_W = 8, BE_W = 4;
  localparam int DATA_W = 32, TAG_W = 4, CAS_LAT = 3;
  localparam int ROW_W = ADDR_W + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic [BE_W-1:0]   req_be;
  logic [TAG_W-1:0]  req_tag;
  logic              req_ready;
  logic sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
  logic [ADDR_W-1:0] sd_addr;
  logic [BE_W-1:0]   sd_be_n;
  logic [DATA_W-1:0] sd_dq_in;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [TAG_W-1:0]  rd_tag;

  always #4 clk = ~clk;

  sdram_page_rd_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .req_col(req_col), .req_be(req_be), .req_tag(req_tag), .req_ready(req_ready),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a10),
    .sd_addr(sd_addr), .sd_be_n(sd_be_n), .sd_dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag)
  );

  int n_chk = 0, n_bad = 0;
  int edge_n = 0;
  int acts_seen = 0;

  // reference model state
  bit               m_open, m_prevrd;
  logic [ROW_W-1:0] m_row;
  int               due_q[$];
  logic [TAG_W-1:0] tagq[$];
  logic [TAG_W-1:0] next_tag;

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, edge_n);
    end
  endtask

  task automatic check_reset_pins();
    check("R1 strobes in reset", {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
    check("R1 rd_valid in reset", rd_valid, 1'b0);
    check("R1 ready in reset", req_ready, 1'b0);
  endtask

  // one clock: inputs set at negedge before the call; returns at next negedge
  task automatic cycle(output bit acc);
    int cmd;
    bit hit;
    logic [2:0] e_strb;
    logic e_a10;
    logic [ADDR_W-1:0] e_addr;
    logic [BE_W-1:0] e_be;
    bit e_rv;
    logic [DATA_W-1:0] e_dat;
    logic [TAG_W-1:0] e_tag;
    string nop_tag;
    #1;
    hit = m_open && (req_row == m_row);
    if (req_valid && hit)              cmd = 2;
    else if (m_prevrd)                 cmd = 0;
    else if (req_valid && !m_open)     cmd = 1;
    else if (req_valid)                cmd = 3;
    else                               cmd = 0;
    nop_tag = m_prevrd ? "R5" : "R7";
    check("R10 req_ready", req_ready, (cmd == 2));
    e_a10 = 1'b0; e_addr = '0; e_be = '1;
    case (cmd)
      1: begin e_strb = 3'b011; e_addr = req_row[ADDR_W-1:0]; e_a10 = req_row[ADDR_W]; end
      2: begin e_strb = 3'b101; e_addr[COL_W-1:0] = req_col;
               e_addr[ADDR_W-1 -: HOLD_W] = m_row[ADDR_W-1 -: HOLD_W]; e_be = ~req_be; end
      3: begin e_strb = 3'b010; e_addr[ADDR_W-1 -: HOLD_W] = m_row[ADDR_W-1 -: HOLD_W];
               e_a10 = 1'b1; end
      default: e_strb = 3'b111;
    endcase
    @(posedge clk);
    edge_n++;
    e_rv = 1'b0; e_dat = '0; e_tag = '0;
    if (due_q.size() > 0 && due_q[0] == edge_n) begin
      e_rv = 1'b1; e_dat = sd_dq_in; e_tag = tagq[0];
      void'(due_q.pop_front()); void'(tagq.pop_front());
    end
    if (cmd == 2) begin due_q.push_back(edge_n + CAS_LAT); tagq.push_back(req_tag); end
    if (cmd == 1) begin m_open = 1'b1; m_row = req_row; end
    if (cmd == 3) m_open = 1'b0;
    m_prevrd = (cmd == 2);
    acc = (cmd == 2);
    @(negedge clk);
    case (cmd)
      1: begin check("R2 activate strobes", {sd_ras_n, sd_cas_n, sd_we_n}, e_strb);
               check("R2 activate a10", sd_a10, e_a10); check("R2 activate row", sd_addr, e_addr);
               acts_seen++; end
      2: begin check("R3 read strobes", {sd_ras_n, sd_cas_n, sd_we_n}, e_strb);
               check("R3 read a10", sd_a10, e_a10); check("R3 read addr", sd_addr[ADDR_W-HOLD_W-1:0], e_addr[ADDR_W-HOLD_W-1:0]);
               check("R8 held bits on read", sd_addr[ADDR_W-1 -: HOLD_W], e_addr[ADDR_W-1 -: HOLD_W]); end
      3: begin check("R6 close-all strobes", {sd_ras_n, sd_cas_n, sd_we_n}, e_strb);
               check("R6 close-all a10", sd_a10, e_a10); check("R6 close-all low addr", sd_addr[ADDR_W-HOLD_W-1:0], '0);
               check("R8 held bits on close-all", sd_addr[ADDR_W-1 -: HOLD_W], e_addr[ADDR_W-1 -: HOLD_W]); end
      default: check({nop_tag, " idle strobes"}, {sd_ras_n, sd_cas_n, sd_we_n}, e_strb);
    endcase
    check("R9 byte masks", sd_be_n, e_be);
    check("R4 rd_valid", rd_valid, e_rv);
    if (e_rv) begin
      check("R4 rd_data", rd_data, e_dat);
      check("R4 rd_tag order", rd_tag, e_tag);
    end
    sd_dq_in = 32'h9e3779b9 * edge_n + 32'h1234;
  endtask

  task automatic idle(int n);
    bit a;
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) cycle(a);
  endtask

  task automatic rd(logic [ROW_W-1:0] row, logic [COL_W-1:0] col, logic [BE_W-1:0] be);
    bit a;
    req_valid = 1'b1; req_row = row; req_col = col; req_be = be; req_tag = next_tag;
    a = 1'b0;
    for (int i = 0; i < 20 && !a; i++) cycle(a);
    check("R10 request consumed", a, 1'b1);
    next_tag = next_tag + 1'b1;
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0;
    m_open = 1'b0; m_prevrd = 1'b0; m_row = '0;
    due_q.delete(); tagq.delete();
    repeat (3) @(negedge clk);
    check_reset_pins();
    rst_n = 1'b1;
    idle(4);
  endtask

  localparam logic [ROW_W-1:0] ROW_A = 15'h0a55;
  localparam logic [ROW_W-1:0] ROW_B = 15'h2a55; // held bits differ
  localparam logic [ROW_W-1:0] ROW_C = 15'h4a55; // only a10 row bit differs
  localparam logic [ROW_W-1:0] ROW_D = 15'h4a54; // only lowest bit differs

  initial begin
    int a0;
    rst_n = 1'b0; req_valid = 1'b0; req_row = '0; req_col = '0; req_be = '0;
    req_tag = '0; sd_dq_in = 32'h0; next_tag = '0;
    @(negedge clk);
    do_reset();
    // R1/R2: first request opens then reads; R3/R9 back-to-back hits
    a0 = acts_seen;
    rd(ROW_A, 8'h01, 4'b0001);
    check("R1 first request activates", acts_seen - a0, 1);
    rd(ROW_A, 8'h02, 4'b1100);
    rd(ROW_A, 8'hff, 4'b1010);
    // R5, R7: quiet period keeps the page
    idle(6);
    a0 = acts_seen;
    rd(ROW_A, 8'h40, 4'b1111);
    check("R7 hit after idle without activate", acts_seen - a0, 0);
    // R6: misses right after a read and after a gap
    rd(ROW_B, 8'h11, 4'b0110);
    idle(3);
    rd(ROW_C, 8'h22, 4'b0011);
    rd(ROW_D, 8'h33, 4'b1001);
    rd(ROW_D, 8'h34, 4'b0100);
    // long hit run, tag wrap, occasional miss
    for (int i = 0; i < 24; i++) begin
      rd((i % 9 == 8) ? ROW_A : ROW_D, 8'(i * 7), 4'(i + 1));
      if (i % 5 == 4) idle(1);
    end
    idle(6);
    // R1: reset closes the page
    do_reset();
    a0 = acts_seen;
    rd(ROW_D, 8'h55, 4'b0101);
    check("R1 page closed after reset", acts_seen - a0, 1);
    idle(6);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule